// File: doc/BRIEF.md
# RTC Interrupt Status and Validity Registers

This block holds the host-visible status and validity registers of a real-time-clock register interface on a byte-wide bus. A one-cycle `update_done` pulse from the timekeeping logic marks the end of each update cycle. The block latches that event in an update-ended flag. It also holds an enable bit in a small control register. When the flag and the enable are both set, a summary request bit becomes 1 and the active-low interrupt line is pulled low.

The host reads the status register to find out why the interrupt fired. That read returns the flags as they were before the access and then clears them, which releases the interrupt line. A second read-only register reports whether the backup supply is valid, taken from a plain input. Reads are registered: `rd_data` updates on the clock edge that samples `rd_en` and holds until the next read.

Top module: `rtc_irq_status`

## Requirements
- R1: A synchronous active-high `rst` clears the update-ended flag, the enable bit and `rd_data`, and releases `irq_n` to 1.
- R2: A one-cycle `update_done` pulse sets the update-ended flag, which reads back as bit 4 of the status register (address `STAT_ADDR`, default 2).
- R3: While the enable bit is 1 and the update-ended flag is set, bit 7 of the status register reads 1 and `irq_n` is 0. `irq_n` goes low on the first edge after `update_done` when the enable bit is already set.
- R4: A status-register read returns the values held before the access in `rd_data` one edge later. It also clears the update-ended flag at that edge, so `irq_n` returns to 1 and a following read shows bits 7 and 4 as 0.
- R5: When `update_done` and a status-register read fall in the same cycle, the read returns the earlier value and the flag stays set afterwards.
- R6: Writing 0 to the enable bit (bit 4 of the control register at `CTRL_ADDR`, default 1) releases `irq_n` and clears status bit 7, but keeps the stored update-ended flag. Writing 1 again reasserts `irq_n`.
- R7: Status bits 6, 5 and 3 to 0 always read 0. Bus writes to the status address change neither the flag nor `irq_n`.
- R8: The validity register (address `VALID_ADDR`, default 3) reads `valid_in` in bit 7 and 0 in bits 6 to 0. Writes to it have no effect.
- R9: The control register reads back the enable bit in bit 4 with all other bits 0. A read of any unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| update_done | input | 1 | One-cycle pulse at the end of an update cycle |
| valid_in | input | 1 | Backup supply valid indication |
| rd_en | input | 1 | Host read strobe, one cycle per access |
| wr_en | input | 1 | Host write strobe, one cycle per access |
| addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A flag that is stuck, lost or cleared at the wrong time shows on `irq_n` at the next clock edge whenever the enable bit is set. It also shows on the next status read, whose data appears one edge after the strobe. If the clear happened before the read data was captured, that same read would return 0 in bits 7 and 4. If the collision order were wrong, the flag would read 0 on the second status read. A stray bit from a write to the status or validity address would show on the next read of that register.

// File: rtl/rtc_irq_status.sv
module rtc_irq_status #(
  parameter int ADDR_W     = 4,
  parameter int CTRL_ADDR  = 1,
  parameter int STAT_ADDR  = 2,
  parameter int VALID_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              update_done,
  input  logic              valid_in,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              irq_n
);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_VALID = ADDR_W'(VALID_ADDR);
  localparam int EN_BIT   = 4;
  localparam int FLAG_BIT = 4;
  localparam int SUM_BIT  = 7;

  logic       ue_flag;
  logic       ue_en;
  logic       irq_req;
  logic [7:0] rd_mux;
  logic       unused_wr_bits;

  wire ctrl_hit  = (addr == A_CTRL);
  wire stat_hit  = (addr == A_STAT);
  wire valid_hit = (addr == A_VALID);
  wire stat_rd   = rd_en && stat_hit;
  wire ctrl_wr   = wr_en && ctrl_hit;

  assign unused_wr_bits = ^{wr_data[7:EN_BIT+1], wr_data[EN_BIT-1:0]};

  assign irq_req = ue_flag & ue_en;
  assign irq_n   = ~irq_req;

  always_comb begin
    rd_mux = '0;
    if (stat_hit) begin
      rd_mux[SUM_BIT]  = irq_req;
      rd_mux[FLAG_BIT] = ue_flag;
    end else if (valid_hit) begin
      rd_mux[7] = valid_in;
    end else if (ctrl_hit) begin
      rd_mux[EN_BIT] = ue_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ue_flag <= 1'b0;
      ue_en   <= 1'b0;
      rd_data <= '0;
    end else begin
      if (update_done)
        ue_flag <= 1'b1;
      else if (stat_rd)
        ue_flag <= 1'b0;
      if (ctrl_wr)
        ue_en <= wr_data[EN_BIT];
      if (rd_en)
        rd_data <= rd_mux;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (irq_n && rd_data == 8'h00 && !ue_flag && !ue_en));

  assert_flag_set_R2: assert property (@(posedge clk) disable iff (rst)
    update_done |=> ue_flag);

  assert_irq_on_event_R3: assert property (@(posedge clk) disable iff (rst)
    (update_done && ue_en && !ctrl_wr) |=> !irq_n);

  assert_read_preclear_R4: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (rd_data[FLAG_BIT] == $past(ue_flag) &&
                 rd_data[SUM_BIT] == $past(ue_flag && ue_en)));

  assert_clear_on_read_R4: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !update_done) |=> (!ue_flag && irq_n));

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && update_done) |=> ue_flag);

  assert_disable_keeps_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !wr_data[EN_BIT] && !update_done && !stat_rd)
      |=> (irq_n && ue_flag == $past(ue_flag)));

  assert_status_zero_bits_R7: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (rd_data[3:0] == 4'h0 && rd_data[6:5] == 2'b00));

  assert_validity_read_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && valid_hit) |=> (rd_data == {$past(valid_in), 7'b0}));

endmodule

// File: tb/test_rtc_irq_status.sv
module test_rtc_irq_status;
  localparam int AW = 4;
  localparam logic [AW-1:0] CTRL = 4'd1, STAT = 4'd2, VALID = 4'd3, SPARE = 4'd9;

  logic clk = 0;
  logic rst, update_done, valid_in, rd_en, wr_en;
  logic [AW-1:0] addr;
  logic [7:0] wr_data, rd_data;
  logic irq_n;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  rtc_irq_status #(.ADDR_W(AW)) i_rtc_irq_status (
    .clk(clk), .rst(rst), .update_done(update_done), .valid_in(valid_in),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_n(irq_n));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] v);
    @(negedge clk); addr = a; wr_data = v; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse_update();
    @(negedge clk); update_done = 1;
    @(negedge clk); update_done = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_write(CTRL, 8'h10);
    pulse_update();
    do_reset();
    check("R1 irq_n after reset", {7'b0, irq_n}, 8'h01);
    check("R1 rd_data after reset", rd_data, 8'h00);
    bus_read(STAT, d);
    check("R1 status after reset", d, 8'h00);
    bus_read(CTRL, d);
    check("R1 control after reset", d, 8'h00);
  endtask

  task automatic t_update_set();
    logic [7:0] d;
    do_reset();
    pulse_update();
    check("R2 irq_n stays high with enable off", {7'b0, irq_n}, 8'h01);
    bus_read(STAT, d);
    check("R2 flag read bit4", d, 8'h10);
  endtask

  task automatic t_irq_enable();
    logic [7:0] d;
    do_reset();
    bus_write(CTRL, 8'h10);
    bus_read(CTRL, d);
    check("R9 control readback", d, 8'h10);
    pulse_update();
    check("R3 irq_n low after event", {7'b0, irq_n}, 8'h00);
    bus_read(STAT, d);
    check("R3 R4 status pre-clear value", d, 8'h90);
    check("R4 irq_n released by read", {7'b0, irq_n}, 8'h01);
    bus_read(STAT, d);
    check("R4 status after clear", d, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    do_reset();
    bus_write(CTRL, 8'h10);
    @(negedge clk); addr = STAT; rd_en = 1; update_done = 1;
    @(negedge clk); rd_en = 0; update_done = 0; d = rd_data;
    check("R5 read in collision returns old value", d, 8'h00);
    check("R5 irq_n low after collision", {7'b0, irq_n}, 8'h00);
    bus_read(STAT, d);
    check("R5 flag kept after collision", d, 8'h90);
  endtask

  task automatic t_disable();
    logic [7:0] d;
    do_reset();
    bus_write(CTRL, 8'hFF);
    bus_read(CTRL, d);
    check("R9 control only bit4 readback", d, 8'h10);
    pulse_update();
    check("R6 irq_n low before disable", {7'b0, irq_n}, 8'h00);
    bus_write(CTRL, 8'hEF);
    check("R6 irq_n released by disable", {7'b0, irq_n}, 8'h01);
    bus_write(CTRL, 8'h10);
    check("R6 irq_n back after re-enable", {7'b0, irq_n}, 8'h00);
    bus_write(CTRL, 8'h00);
    bus_read(STAT, d);
    check("R6 flag retained, summary clear", d, 8'h10);
  endtask

  task automatic t_status_write();
    logic [7:0] d;
    do_reset();
    bus_write(CTRL, 8'h10);
    bus_write(STAT, 8'hFF);
    check("R7 status write does not raise irq", {7'b0, irq_n}, 8'h01);
    bus_read(STAT, d);
    check("R7 status write ignored (clear)", d, 8'h00);
    pulse_update();
    bus_write(STAT, 8'h00);
    check("R7 status write does not clear irq", {7'b0, irq_n}, 8'h00);
    bus_read(STAT, d);
    check("R7 zero bits with flags set", d & 8'h6F, 8'h00);
  endtask

  task automatic t_validity();
    logic [7:0] d;
    do_reset();
    valid_in = 1;
    bus_write(VALID, 8'h00);
    bus_read(VALID, d);
    check("R8 validity reads 1", d, 8'h80);
    valid_in = 0;
    bus_write(VALID, 8'hFF);
    bus_read(VALID, d);
    check("R8 validity reads 0", d, 8'h00);
    valid_in = 1;
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    do_reset();
    bus_write(CTRL, 8'h10);
    pulse_update();
    bus_read(SPARE, d);
    check("R9 unmapped read zero", d, 8'h00);
    check("R9 unmapped read keeps irq", {7'b0, irq_n}, 8'h00);
  endtask

  initial begin
    rst = 1; update_done = 0; valid_in = 1; rd_en = 0; wr_en = 0;
    addr = '0; wr_data = '0;
    repeat (2) @(negedge clk);
    rst = 0;
    t_reset();
    t_update_set();
    t_irq_enable();
    t_collision();
    t_disable();
    t_status_write();
    t_validity();
    t_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule